// File: doc/BRIEF.md
# One-Time-Programmable Fuse Array Controller

This block sits between a simple 32-bit register bus and a behavioural model of a one-time-programmable fuse array. The array has eight banks of 256 byte-wide locations. Software can read the mirror of the fuses directly from a fuse window in the address space. It can also overwrite mirror bytes (an override). Two timed operations exist. A sense cycle copies one addressed array byte into a sense-data register. A program cycle blows one addressed fuse bit.

The target of a timed operation comes from two address registers. The upper one carries the bank and the top three row bits. The lower one carries the five low row bits and the bit index. A program cycle only blows a fuse when the key register holds 0xAA, the control register's disable bit is clear, and the bank is not write-protected. Completion, failures and a busy flag show up in a status register and an error register. Both registers clear by writing ones. Each has a mask register, and the masks combine into one interrupt line.

Top module: `fuse_ctrl`

## Requirements
- R1: Word addresses with bit 11 clear select registers: 0 status, 1 status mask, 2 error, 3 error mask, 4 control, 5 upper address, 6 lower address, 7 sense data, 8 key. Addresses with bit 11 set select the fuse window, with the bank in bits 10:8 and the location in bits 7:0.
- R2: After reset, status, error, control, sense data and the irq output all read zero, and every mirror byte reads zero.
- R3: The target bank is upper-address bits 5:3. The location is {upper bits 2:0, lower bits 7:3}. The bit index is lower bits 2:0. A program start (control bit 0) with key 0xAA, control bit 7 clear and an unprotected bank sets that bit to 1 in both the array and the mirror, and sets status bit 1 at the end of the cycle.
- R4: A program start with the key not equal to 0xAA, or with control bit 7 set, blows nothing, sets error bit 7 and leaves status bit 1 clear.
- R5: A permitted program start to a write-protected bank (bank 5 by default) blows nothing and sets error bit 6.
- R6: A sense start (control bit 3) loads the addressed array byte into sense data and sets status bit 0. On a read-protected bank (bank 7 by default) it sets error bit 2 and leaves sense data unchanged. If bits 0 and 3 are both written, only the program starts.
- R7: Status bit 7 (busy) is high for exactly 4 cycles during a sense and (length+1)*4 cycles during a program, where length is control bits 6:4. Control bits 0 and 3 read 1 while the cycle runs and clear when it ends.
- R8: A control write while busy is ignored. The control value does not change and no second operation starts.
- R9: A fuse-window read returns the mirror byte. On a read-protected bank it returns 0 and sets error bit 4.
- R10: A fuse-window write stores data OR the blown fuses into the mirror, so blown bits stay 1. On an override-protected bank (bank 6 by default) the write is refused, the mirror is unchanged and error bit 5 is set.
- R11: Writing 1 to status bits 1:0 or to any error bit clears that bit. Writing 0 leaves it unchanged.
- R12: irq is high when any status bit is set under its status-mask bit, or any error bit is set under its error-mask bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| busWrEn | input | 1 | Write strobe, one cycle per write |
| busRdEn | input | 1 | Read strobe, one cycle per read |
| busAddr | input | 12 | Word address |
| busWrData | input | 32 | Write data, low byte used |
| busRdData | output | 32 | Combinational read data |
| irq | output | 1 | Masked status/error interrupt |

## Verification
The bound assertions hold on every cycle. They check that done flags rise only on the edge where busy falls, and that busy never runs longer than the longest program cycle. They check that the start bits are clear whenever busy drops, and that control writes during busy leave the stored fields alone. They also check that the read-protect and override-protect errors rise only right after a fuse-window access. The bench scenarios are needed to show the rest: the data effects, meaning which bit was blown, what the sense register holds, that blown bits survive an override, and exact cycle counts for each program length.

// File: rtl/fuse_pkg.sv
package fuse_pkg;
  localparam int STAT_BUSY  = 7;
  localparam int STAT_PDONE = 1;
  localparam int STAT_SDONE = 0;

  localparam int ERR_PROG  = 7;
  localparam int ERR_WPROT = 6;
  localparam int ERR_OVR   = 5;
  localparam int ERR_RD    = 4;
  localparam int ERR_SENSE = 2;

  localparam int CTL_DIS   = 7;
  localparam int CTL_SENSE = 3;
  localparam int CTL_PROG  = 0;

  localparam logic [7:0] PROG_KEY = 8'hAA;

  typedef enum logic [3:0] {
    REG_STAT  = 4'd0,
    REG_STATM = 4'd1,
    REG_ERR   = 4'd2,
    REG_ERRM  = 4'd3,
    REG_CTRL  = 4'd4,
    REG_ADRHI = 4'd5,
    REG_ADRLO = 4'd6,
    REG_SDATA = 4'd7,
    REG_KEY   = 4'd8
  } regSel_e;

  // datapath -> control: start requests and verdicts taken at start time
  typedef struct packed {
    logic       startProg;
    logic       startSense;
    logic [2:0] progLen;
    logic       progOk;
    logic       progDenied;
    logic       wpFail;
    logic       senseOk;
  } opReq_t;

  // control -> datapath: strobes
  typedef struct packed {
    logic busy;
    logic opEnd;
    logic blow;
    logic progErr;
    logic wpErr;
    logic senseLoad;
    logic senseErr;
  } opStrobe_t;
endpackage

// File: rtl/fuse_op_ctrl.sv
module fuse_op_ctrl
  import fuse_pkg::*;
#(
  parameter int PROG_UNIT    = 4,
  parameter int SENSE_CYCLES = 4
) (
  input  logic      clk,
  input  logic      rstN,
  input  opReq_t    req,
  output opStrobe_t strobe
);
  localparam int MAX_CYC = (8 * PROG_UNIT > SENSE_CYCLES) ? 8 * PROG_UNIT : SENSE_CYCLES;
  localparam int CNT_W   = $clog2(MAX_CYC + 1);

  logic             busyQ;
  logic [CNT_W-1:0] cnt;
  logic             opProgQ;
  logic             progOkQ;
  logic             progDeniedQ;
  logic             wpFailQ;
  logic             senseOkQ;
  logic             lastCycle;

  assign lastCycle = busyQ && (cnt == '0);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      busyQ       <= 1'b0;
      cnt         <= '0;
      opProgQ     <= 1'b0;
      progOkQ     <= 1'b0;
      progDeniedQ <= 1'b0;
      wpFailQ     <= 1'b0;
      senseOkQ    <= 1'b0;
    end else if (!busyQ && (req.startProg || req.startSense)) begin
      busyQ       <= 1'b1;
      opProgQ     <= req.startProg;
      progOkQ     <= req.progOk;
      progDeniedQ <= req.progDenied;
      wpFailQ     <= req.wpFail;
      senseOkQ    <= req.senseOk;
      if (req.startProg)
        cnt <= CNT_W'((int'(req.progLen) + 1) * PROG_UNIT - 1);
      else
        cnt <= CNT_W'(SENSE_CYCLES - 1);
    end else if (lastCycle) begin
      busyQ <= 1'b0;
    end else if (busyQ) begin
      cnt <= cnt - 1'b1;
    end
  end

  always_comb begin
    strobe.busy      = busyQ;
    strobe.opEnd     = lastCycle;
    strobe.blow      = lastCycle && opProgQ && progOkQ;
    strobe.progErr   = lastCycle && opProgQ && progDeniedQ;
    strobe.wpErr     = lastCycle && opProgQ && wpFailQ;
    strobe.senseLoad = lastCycle && !opProgQ && senseOkQ;
    strobe.senseErr  = lastCycle && !opProgQ && !senseOkQ;
  end
endmodule

// File: rtl/fuse_datapath.sv
module fuse_datapath
  import fuse_pkg::*;
#(
  parameter int NUM_BANKS      = 8,
  parameter int WORDS_PER_BANK = 256,
  parameter logic [NUM_BANKS-1:0] RD_PROT  = 8'h80,
  parameter logic [NUM_BANKS-1:0] OVR_PROT = 8'h40,
  parameter logic [NUM_BANKS-1:0] WR_PROT  = 8'h20,
  parameter int ADDR_W = 12
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busWrEn,
  input  logic              busRdEn,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [31:0]       busWrData,
  output logic [31:0]       busRdData,
  output logic              irq,
  input  opStrobe_t         strobe,
  output opReq_t            req
);
  localparam int BANK_W = $clog2(NUM_BANKS);
  localparam int WORD_W = $clog2(WORDS_PER_BANK);
  localparam int IDX_W  = BANK_W + WORD_W;
  localparam int DEPTH  = NUM_BANKS * WORDS_PER_BANK;
  localparam int FUSE_SEL = ADDR_W - 1;

  logic [7:0] fuseArr [DEPTH];
  logic [7:0] mirror  [DEPTH];

  logic [1:0] statDone;
  logic [1:0] statMask;
  logic [7:0] errQ;
  logic [7:0] errMask;
  logic [7:0] ctrlQ;
  logic [5:0] addrHi;
  logic [7:0] addrLo;
  logic [7:0] senseData;
  logic [7:0] keyQ;
  logic [IDX_W-1:0] opIdx;
  logic [2:0]       opBit;
  logic             busyNow;

  logic [7:0]  wByte;
  logic [23:0] unusedHiData;
  assign wByte        = busWrData[7:0];
  assign unusedHiData = busWrData[31:8];
  assign busyNow      = strobe.busy;

  // bus decode
  logic              fuseSel;
  logic              regHit;
  logic [3:0]        regOff;
  logic [BANK_W-1:0] busBank;
  logic [IDX_W-1:0]  busIdx;
  assign fuseSel = busAddr[FUSE_SEL];
  assign regOff  = busAddr[3:0];
  assign regHit  = !fuseSel && (busAddr[FUSE_SEL-1:4] == '0);
  assign busBank = busAddr[WORD_W +: BANK_W];
  assign busIdx  = busAddr[IDX_W-1:0];

  function automatic logic regWr(input logic [3:0] off);
    return busWrEn && regHit && (regOff == off);
  endfunction

  // target of the timed operation from the split address registers
  logic [7:0]        rowFull;
  logic [BANK_W-1:0] tgtBank;
  logic [IDX_W-1:0]  tgtIdx;
  assign rowFull = {addrHi[2:0], addrLo[7:3]};
  assign tgtBank = addrHi[3 +: BANK_W];
  assign tgtIdx  = {tgtBank, rowFull[WORD_W-1:0]};

  logic ctrlWr, startAcc, keyOk, dis;
  assign ctrlWr   = regWr(REG_CTRL) && !busyNow;
  assign startAcc = ctrlWr && (wByte[CTL_PROG] || wByte[CTL_SENSE]);
  assign keyOk    = (keyQ == PROG_KEY);
  assign dis      = wByte[CTL_DIS];

  always_comb begin
    req.startProg  = ctrlWr && wByte[CTL_PROG];
    req.startSense = ctrlWr && wByte[CTL_SENSE] && !wByte[CTL_PROG];
    req.progLen    = wByte[6:4];
    req.progDenied = !keyOk || dis;
    req.wpFail     = keyOk && !dis && WR_PROT[tgtBank];
    req.progOk     = keyOk && !dis && !WR_PROT[tgtBank];
    req.senseOk    = !RD_PROT[tgtBank];
  end

  // read mux
  always_comb begin
    busRdData = '0;
    if (fuseSel) begin
      if (!RD_PROT[busBank]) busRdData[7:0] = mirror[busIdx];
    end else if (regHit) begin
      case (regOff)
        REG_STAT:  busRdData[7:0] = {busyNow, 5'b0, statDone};
        REG_STATM: busRdData[7:0] = {6'b0, statMask};
        REG_ERR:   busRdData[7:0] = errQ;
        REG_ERRM:  busRdData[7:0] = errMask;
        REG_CTRL:  busRdData[7:0] = ctrlQ;
        REG_ADRHI: busRdData[7:0] = {2'b0, addrHi};
        REG_ADRLO: busRdData[7:0] = addrLo;
        REG_SDATA: busRdData[7:0] = senseData;
        REG_KEY:   busRdData[7:0] = keyQ;
        default:   busRdData = '0;
      endcase
    end
  end

  // next status / error
  logic [1:0] statNext;
  logic [7:0] errNext;
  logic       ovrWr, ovrOk;
  assign ovrWr = busWrEn && fuseSel;
  assign ovrOk = ovrWr && !OVR_PROT[busBank];

  always_comb begin
    statNext = statDone;
    if (regWr(REG_STAT)) statNext = statNext & ~wByte[1:0];
    if (strobe.blow)      statNext[STAT_PDONE] = 1'b1;
    if (strobe.senseLoad) statNext[STAT_SDONE] = 1'b1;

    errNext = errQ;
    if (regWr(REG_ERR)) errNext = errNext & ~wByte;
    if (strobe.progErr)  errNext[ERR_PROG]  = 1'b1;
    if (strobe.wpErr)    errNext[ERR_WPROT] = 1'b1;
    if (strobe.senseErr) errNext[ERR_SENSE] = 1'b1;
    if (ovrWr && OVR_PROT[busBank]) errNext[ERR_OVR] = 1'b1;
    if (busRdEn && fuseSel && RD_PROT[busBank]) errNext[ERR_RD] = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      statDone  <= '0;
      statMask  <= '0;
      errQ      <= '0;
      errMask   <= '0;
      ctrlQ     <= '0;
      addrHi    <= '0;
      addrLo    <= '0;
      senseData <= '0;
      keyQ      <= '0;
      opIdx     <= '0;
      opBit     <= '0;
    end else begin
      statDone <= statNext;
      errQ     <= errNext;
      if (regWr(REG_STATM)) statMask <= wByte[1:0];
      if (regWr(REG_ERRM))  errMask  <= wByte;
      if (regWr(REG_ADRHI)) addrHi   <= wByte[5:0];
      if (regWr(REG_ADRLO)) addrLo   <= wByte;
      if (regWr(REG_KEY))   keyQ     <= wByte;
      if (ctrlWr) ctrlQ <= wByte;
      if (strobe.opEnd) begin
        ctrlQ[CTL_PROG]  <= 1'b0;
        ctrlQ[CTL_SENSE] <= 1'b0;
      end
      if (startAcc) begin
        opIdx <= tgtIdx;
        opBit <= addrLo[2:0];
      end
      if (strobe.senseLoad) senseData <= fuseArr[opIdx];
    end
  end

  // fuse array model and its mirror
  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < DEPTH; i++) begin
        fuseArr[i] <= '0;
        mirror[i]  <= '0;
      end
    end else begin
      if (ovrOk) mirror[busIdx] <= wByte | fuseArr[busIdx];
      if (strobe.blow) begin
        fuseArr[opIdx][opBit] <= 1'b1;
        mirror[opIdx][opBit]  <= 1'b1;
      end
    end
  end

  assign irq = |(statDone & statMask) || |(errQ & errMask);
endmodule

// File: rtl/fuse_ctrl.sv
module fuse_ctrl
  import fuse_pkg::*;
#(
  parameter int NUM_BANKS      = 8,
  parameter int WORDS_PER_BANK = 256,
  parameter int PROG_UNIT      = 4,
  parameter int SENSE_CYCLES   = 4,
  parameter logic [NUM_BANKS-1:0] RD_PROT  = 8'h80,
  parameter logic [NUM_BANKS-1:0] OVR_PROT = 8'h40,
  parameter logic [NUM_BANKS-1:0] WR_PROT  = 8'h20
) (
  input  logic clk,
  input  logic rstN,
  input  logic busWrEn,
  input  logic busRdEn,
  input  logic [$clog2(NUM_BANKS)+$clog2(WORDS_PER_BANK):0] busAddr,
  input  logic [31:0] busWrData,
  output logic [31:0] busRdData,
  output logic irq
);
  localparam int ADDR_W  = $clog2(NUM_BANKS) + $clog2(WORDS_PER_BANK) + 1;
  localparam int MAX_CYC = (8 * PROG_UNIT > SENSE_CYCLES) ? 8 * PROG_UNIT : SENSE_CYCLES;

  opReq_t    req;
  opStrobe_t strobe;

  fuse_op_ctrl #(
    .PROG_UNIT(PROG_UNIT),
    .SENSE_CYCLES(SENSE_CYCLES)
  ) u_ctl (
    .clk(clk),
    .rstN(rstN),
    .req(req),
    .strobe(strobe)
  );

  fuse_datapath #(
    .NUM_BANKS(NUM_BANKS),
    .WORDS_PER_BANK(WORDS_PER_BANK),
    .RD_PROT(RD_PROT),
    .OVR_PROT(OVR_PROT),
    .WR_PROT(WR_PROT),
    .ADDR_W(ADDR_W)
  ) u_dp (
    .clk(clk),
    .rstN(rstN),
    .busWrEn(busWrEn),
    .busRdEn(busRdEn),
    .busAddr(busAddr),
    .busWrData(busWrData),
    .busRdData(busRdData),
    .irq(irq),
    .strobe(strobe),
    .req(req)
  );
endmodule

// File: rtl/fuse_ctrl_checker.sv
module fuse_ctrl_checker #(
  parameter int ADDR_W  = 12,
  parameter int MAX_CYC = 32
) (
  input logic              clk,
  input logic              rstN,
  input logic              busWrEn,
  input logic              busRdEn,
  input logic [ADDR_W-1:0] busAddr,
  input logic              busy,
  input logic [1:0]        statDone,
  input logic [7:0]        errQ,
  input logic [7:0]        ctrlQ
);
  logic [31:0] busyRun;
  always_ff @(posedge clk) begin
    if (!rstN)     busyRun <= '0;
    else if (busy) busyRun <= busyRun + 1;
    else           busyRun <= '0;
  end

  p_progdone_at_end_r3: assert property (@(posedge clk) disable iff (!rstN)
    $rose(statDone[1]) |-> ($past(busy) && !busy));

  p_sensedone_at_end_r6: assert property (@(posedge clk) disable iff (!rstN)
    $rose(statDone[0]) |-> ($past(busy) && !busy));

  p_busy_bound_r7: assert property (@(posedge clk) disable iff (!rstN)
    busyRun <= MAX_CYC);

  p_start_bits_clear_r7: assert property (@(posedge clk) disable iff (!rstN)
    $fell(busy) |-> (!ctrlQ[0] && !ctrlQ[3]));

  p_ctrl_hold_busy_r8: assert property (@(posedge clk) disable iff (!rstN)
    (busy && busWrEn && busAddr == ADDR_W'(4)) |=> ($stable(ctrlQ[7:4]) && $stable(ctrlQ[2:1])));

  p_rd_prot_cause_r9: assert property (@(posedge clk) disable iff (!rstN)
    $rose(errQ[4]) |-> $past(busRdEn && busAddr[ADDR_W-1]));

  p_ovr_prot_cause_r10: assert property (@(posedge clk) disable iff (!rstN)
    $rose(errQ[5]) |-> $past(busWrEn && busAddr[ADDR_W-1]));
endmodule

bind fuse_ctrl fuse_ctrl_checker #(
  .ADDR_W(ADDR_W),
  .MAX_CYC(MAX_CYC)
) u_chk (
  .clk(clk),
  .rstN(rstN),
  .busWrEn(busWrEn),
  .busRdEn(busRdEn),
  .busAddr(busAddr),
  .busy(u_dp.busyNow),
  .statDone(u_dp.statDone),
  .errQ(u_dp.errQ),
  .ctrlQ(u_dp.ctrlQ)
);

// File: tb/fuse_ctrl_bench.sv
module fuse_ctrl_bench;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        busWrEn = 1'b0;
  logic        busRdEn = 1'b0;
  logic [11:0] busAddr = '0;
  logic [31:0] busWrData = '0;
  logic [31:0] busRdData;
  logic        irq;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #10 clk = ~clk;

  fuse_ctrl u_fuse_ctrl (
    .clk(clk), .rstN(rstN), .busWrEn(busWrEn), .busRdEn(busRdEn),
    .busAddr(busAddr), .busWrData(busWrData), .busRdData(busRdData), .irq(irq)
  );

  localparam logic [11:0] A_STAT = 12'd0, A_STATM = 12'd1, A_ERR = 12'd2, A_ERRM = 12'd3,
    A_CTRL = 12'd4, A_HI = 12'd5, A_LO = 12'd6, A_SDAT = 12'd7, A_KEY = 12'd8;

  typedef struct packed {
    logic [2:0] bank;
    logic [7:0] word;
    logic [7:0] data;
    logic [7:0] expRd;
    logic       expOvrErr;
    logic       expRdErr;
  } ovrVec_t;

  localparam ovrVec_t VECS [6] = '{
    '{3'd0, 8'h00, 8'h5A, 8'h5A, 1'b0, 1'b0},
    '{3'd2, 8'hFF, 8'hC3, 8'hC3, 1'b0, 1'b0},
    '{3'd0, 8'h00, 8'h11, 8'h11, 1'b0, 1'b0},
    '{3'd6, 8'h10, 8'h77, 8'h00, 1'b1, 1'b0},
    '{3'd7, 8'h02, 8'h44, 8'h00, 1'b0, 1'b1},
    '{3'd4, 8'h80, 8'hFF, 8'hFF, 1'b0, 1'b0}
  };

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    busWrEn = 1'b1; busAddr = a; busWrData = d;
    @(negedge clk);
    busWrEn = 1'b0;
  endtask

  task automatic rd(input logic [11:0] a, output logic [31:0] d);
    busRdEn = 1'b1; busAddr = a;
    #1 d = busRdData;
    @(negedge clk);
    busRdEn = 1'b0;
  endtask

  task automatic waitIdle(output int n);
    logic [31:0] s;
    n = 0;
    for (int k = 0; k < 200; k++) begin
      rd(A_STAT, s);
      if (!s[7]) break;
      n++;
    end
  endtask

  function automatic logic [11:0] fa(input logic [2:0] b, input logic [7:0] w);
    return {1'b1, b, w};
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    int n;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R2 reset state
    rd(A_STAT, d); check("R2 status", d, 0);
    rd(A_ERR, d);  check("R2 error", d, 0);
    rd(A_CTRL, d); check("R2 control", d, 0);
    rd(A_SDAT, d); check("R2 sense data", d, 0);
    check("R2 irq", {31'b0, irq}, 0);
    rd(fa(3'd3, 8'h44), d); check("R2 mirror", d, 0);

    // R1 R9 R10 override/read vector table
    foreach (VECS[i]) begin
      wr(A_ERR, 32'hFF);
      wr(fa(VECS[i].bank, VECS[i].word), {24'h0, VECS[i].data});
      rd(fa(VECS[i].bank, VECS[i].word), d);
      check($sformatf("R9 R10 vec%0d read", i), d, {24'h0, VECS[i].expRd});
      rd(A_ERR, d);
      check($sformatf("R9 R10 vec%0d err", i), d,
            {26'h0, VECS[i].expOvrErr, VECS[i].expRdErr, 4'h0});
    end
    wr(A_ERR, 32'hFF);

    // R4 program without key: bank1 word 0x25 bit3
    wr(A_HI, 32'h09); wr(A_LO, 32'h2B);
    wr(A_CTRL, 32'h01);
    waitIdle(n); check("R7 denied prog length", n, 4);
    rd(A_ERR, d);  check("R4 no key err", d, 32'h80);
    rd(A_STAT, d); check("R4 no done", d, 0);
    rd(fa(3'd1, 8'h25), d); check("R4 no blow", d, 0);
    wr(A_ERR, 32'hFF);

    // R3 R7 program with key, length 2
    wr(A_KEY, 32'hAA);
    wr(A_CTRL, 32'h21);
    waitIdle(n); check("R7 prog length 12", n, 12);
    rd(A_STAT, d); check("R3 prog done", d, 32'h02);
    rd(A_ERR, d);  check("R3 no err", d, 0);
    rd(A_CTRL, d); check("R7 start bit cleared", d, 32'h20);
    rd(fa(3'd1, 8'h25), d); check("R3 mirror bit", d, 32'h08);

    // R6 sense
    wr(A_CTRL, 32'h08);
    waitIdle(n); check("R7 sense length", n, 4);
    rd(A_STAT, d); check("R6 sense done", d, 32'h03);
    rd(A_SDAT, d); check("R6 sense data", d, 32'h08);

    // R11 write-one-to-clear
    wr(A_STAT, 32'h02); rd(A_STAT, d); check("R11 clear prog done", d, 32'h01);
    wr(A_STAT, 32'h00); rd(A_STAT, d); check("R11 zero write keeps", d, 32'h01);
    wr(A_STAT, 32'h01); rd(A_STAT, d); check("R11 clear sense done", d, 0);

    // R10 blown bit survives override
    wr(fa(3'd1, 8'h25), 32'h01);
    rd(fa(3'd1, 8'h25), d); check("R10 sticky blown bit", d, 32'h09);

    // R6 sense of read-protected bank 7
    wr(A_HI, 32'h38); wr(A_LO, 32'h00);
    wr(A_CTRL, 32'h08); waitIdle(n);
    rd(A_ERR, d);  check("R6 sense err", d, 32'h04);
    rd(A_STAT, d); check("R6 no sense done", d, 0);
    rd(A_SDAT, d); check("R6 sense data kept", d, 32'h08);
    wr(A_ERR, 32'hFF);

    // R5 write-protected bank 5
    wr(A_HI, 32'h28); wr(A_LO, 32'h00);
    wr(A_CTRL, 32'h01); waitIdle(n);
    rd(A_ERR, d); check("R5 wp err", d, 32'h40);
    rd(A_STAT, d); check("R5 no done", d, 0);
    wr(A_CTRL, 32'h08); waitIdle(n);
    rd(A_SDAT, d); check("R5 bank5 unblown", d, 0);
    wr(A_ERR, 32'hFF); wr(A_STAT, 32'hFF);

    // R4 disable bit, bank1 word 0x25 bit2
    wr(A_HI, 32'h09); wr(A_LO, 32'h2A);
    wr(A_CTRL, 32'h81); waitIdle(n);
    rd(A_ERR, d); check("R4 disabled err", d, 32'h80);
    rd(fa(3'd1, 8'h25), d); check("R4 disabled no blow", d, 32'h09);
    wr(A_ERR, 32'hFF);

    // R6 both start bits: program only
    wr(A_CTRL, 32'h09); waitIdle(n);
    rd(A_STAT, d); check("R6 program wins", d, 32'h02);
    rd(fa(3'd1, 8'h25), d); check("R3 bit2 blown", d, 32'h0D);
    wr(A_STAT, 32'hFF);

    // R8 control write while busy ignored (target bit1)
    wr(A_LO, 32'h29);
    wr(A_CTRL, 32'h08);
    wr(A_CTRL, 32'h71);
    waitIdle(n);
    rd(A_STAT, d); check("R8 only sense done", d, 32'h01);
    rd(A_CTRL, d); check("R8 control unchanged", d, 0);
    rd(A_SDAT, d); check("R8 sense data", d, 32'h0C);
    rd(fa(3'd1, 8'h25), d); check("R8 no blow", d, 32'h0D);

    // R12 irq
    check("R12 irq unmasked", {31'b0, irq}, 0);
    wr(A_STATM, 32'h01); check("R12 irq status", {31'b0, irq}, 1);
    wr(A_STAT, 32'h01);  check("R12 irq cleared", {31'b0, irq}, 0);
    wr(A_ERRM, 32'h10);
    rd(fa(3'd7, 8'h00), d); check("R9 protected read", d, 0);
    check("R12 irq error", {31'b0, irq}, 1);

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule